// File: doc/BRIEF.md
# Fuse Map Access and Security Controller

This block is the test and programming port of a programmable logic array. A host shifts in fixed-length command frames one bit at a time over a valid/ready bit stream. Each frame holds an operation code, an address field and a data field. The block can do the following:

- write and read the configuration fuse map, which is held in flip-flops;
- write and read a 64-bit user signature, organised as eight bytes;
- force chosen output registers of the array high or low (preload);
- set a security bit.

The only way to clear the security bit is an erase of the whole fuse map.

Read results leave the block on a second valid/ready bit stream, most significant bit first. When the security bit is set, fuse readback and preload are refused, and each refusal raises a sticky denial flag. Signature access is never affected by the security bit. The fuse map is driven out in parallel to the array. The preload result is a one-cycle enable mask together with the values to load.

Top module: `fuse_access_ctrl`

## Requirements
- R1: A frame is 20 bits sent MSB first: opcode[3:0], then address[7:0], then data[7:0]. A bit is taken on a clock edge where in_valid and in_ready are both high. A one-cycle frame_sync pulse throws away any partial frame, so the next accepted bit is the first bit of a new frame.
- R2: in_ready goes low in the cycle after the 20th bit is accepted. It stays low as long as a read response is still being sent on the output stream (out_valid high).
- R3: A read answers with 8 bits, MSB first, on out_valid/out_bit. A bit is consumed on an edge where out_valid and out_ready are both high. While out_ready is low, out_valid and out_bit hold their values. out_valid drops after the eighth bit.
- R4: Opcode 1 writes the data field into the fuse word chosen by the address. Opcode 2 reads that word back. Only the low log2(32)=5 address bits select the word, so address 35 names word 3. Word w appears on fuse_map[8w+7:8w].
- R5: Opcode 3 writes and opcode 4 reads the signature byte chosen by address bits [2:0]. Both work the same whether or not the security bit is set.
- R6: Opcode 5 is preload. The address field is a mask of output registers and the data field holds their values. One cycle after the command, preload_en equals the mask for exactly one cycle and preload_val equals the data field.
- R7: Opcode 6 sets the secure output in the cycle after the command. The very next command already sees the bit set. Only opcode 7 clears it.
- R8: A fuse read while secure is high returns eight zero bits and sets the sticky denied output.
- R9: A preload while secure is high leaves preload_en at zero and sets denied.
- R10: Opcode 7 (erase) sets every fuse word to 0xFF and clears secure. It leaves the signature unchanged.
- R11: Opcode 8 clears denied. Opcodes 0 and 9 to 15 change no fuse, signature, flag or output and produce no response.
- R12: After reset, every fuse word is 0xFF, the signature is zero, secure, denied, preload_en and out_valid are low, and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Discards a partial frame |
| in_valid | input | 1 | Command bit valid |
| in_bit | input | 1 | Command bit |
| in_ready | output | 1 | Command bit can be accepted |
| out_valid | output | 1 | Response bit valid |
| out_bit | output | 1 | Response bit |
| out_ready | input | 1 | Host takes the response bit |
| fuse_map | output | 256 | Whole fuse map, word w at bits [8w+7:8w] |
| preload_en | output | 8 | One-cycle preload mask |
| preload_val | output | 8 | Values to load into the output registers |
| secure | output | 1 | Security bit |
| denied | output | 1 | Sticky flag for a refused operation |

## Verification
The hardest case to reach is a response that is stalled part-way through while a second command is waiting at the input. The stimulus holds out_ready low after a read frame. It then checks that in_ready stays low and that the first response bit does not change, before it drains the byte. The security cases follow each other in one order: set the bit, then a blocked fuse read, a signature access, a blocked preload observed over several cycles, and finally an erase. This shows that the bit is sticky, that it takes effect at once, and that erase is the only way to clear it.

// File: rtl/fac_pkg.sv
package fac_pkg;
  localparam int OP_W    = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 4'd0,
    OP_FUSE_WR  = 4'd1,
    OP_FUSE_RD  = 4'd2,
    OP_SIG_WR   = 4'd3,
    OP_SIG_RD   = 4'd4,
    OP_PRELOAD  = 4'd5,
    OP_SECURE   = 4'd6,
    OP_ERASE    = 4'd7,
    OP_CLR_DENY = 4'd8
  } fac_op_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } fac_frame_t;
endpackage

// File: rtl/fac_rx.sv
module fac_rx
  import fac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       hold,
  output logic       in_ready,
  output logic       frame_vld,
  output fac_frame_t frame
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               take;

  assign in_ready = !hold && !frame_vld;
  assign take     = in_valid && in_ready;
  assign frame    = fac_frame_t'(sh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= 1'b0;
      if (sync) begin
        cnt_q <= '0;
      end else if (take) begin
        sh_q <= {sh_q[FRAME_W-2:0], in_bit};
        if (cnt_q == CNT_W'(FRAME_W - 1)) begin
          cnt_q     <= '0;
          frame_vld <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_SYNC_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !frame_vld); // R1
  AST_FRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld && in_ready == !hold); // R2
endmodule

// File: rtl/fac_tx.sv
module fac_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         out_ready,
  output logic         out_valid,
  output logic         out_bit
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign out_valid = (cnt_q != '0);
  assign out_bit   = sh_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= load_byte;
      cnt_q <= CNT_W'(W);
    end else if (out_valid && out_ready) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !load |=> out_valid && $stable(out_bit)); // R3
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid); // R2
endmodule

// File: rtl/fac_store.sv
module fac_store
  import fac_pkg::*;
#(
  parameter int              WORDS     = 32,
  parameter int              SIG_BYTES = 8,
  parameter logic [DATA_W-1:0] BLANK   = '1,
  localparam int             FA_W      = $clog2(WORDS),
  localparam int             SA_W      = $clog2(SIG_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fuse_we,
  input  logic                    sig_we,
  input  logic                    erase,
  input  logic                    set_sec,
  input  logic [FA_W-1:0]         fuse_addr,
  input  logic [SA_W-1:0]         sig_addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       fuse_rdata,
  output logic [DATA_W-1:0]       sig_rdata,
  output logic [WORDS*DATA_W-1:0] fuse_flat,
  output logic                    secure
);
  logic [SIG_BYTES*DATA_W-1:0] sig_flat;

  for (genvar w = 0; w < WORDS; w++) begin : g_fuse
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= BLANK;
      else if (erase)                              q <= BLANK;
      else if (fuse_we && fuse_addr == FA_W'(w))   q <= wdata;
    end
    assign fuse_flat[w*DATA_W +: DATA_W] = q;
  end

  for (genvar s = 0; s < SIG_BYTES; s++) begin : g_sig
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= '0;
      else if (sig_we && sig_addr == SA_W'(s))   q <= wdata;
    end
    assign sig_flat[s*DATA_W +: DATA_W] = q;
  end

  assign fuse_rdata = fuse_flat[fuse_addr*DATA_W +: DATA_W];
  assign sig_rdata  = sig_flat[sig_addr*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       secure <= 1'b0;
    else if (erase)   secure <= 1'b0;
    else if (set_sec) secure <= 1'b1;
  end

  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    secure && !erase |=> secure); // R7
  AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> !secure && fuse_flat[DATA_W-1:0] == BLANK); // R10
  AST_SIG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_we |=> $stable(sig_flat)); // R10
endmodule

// File: rtl/fuse_access_ctrl.sv
module fuse_access_ctrl
  import fac_pkg::*;
#(
  parameter int FUSE_WORDS = 32,
  parameter int SIG_BYTES  = 8,
  parameter int NUM_OUT    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_sync,
  input  logic                         in_valid,
  input  logic                         in_bit,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic                         out_bit,
  input  logic                         out_ready,
  output logic [FUSE_WORDS*DATA_W-1:0] fuse_map,
  output logic [NUM_OUT-1:0]           preload_en,
  output logic [NUM_OUT-1:0]           preload_val,
  output logic                         secure,
  output logic                         denied
);
  localparam int FA_W = $clog2(FUSE_WORDS);
  localparam int SA_W = $clog2(SIG_BYTES);

  fac_frame_t        cmd;
  logic              cmd_vld;
  logic              tx_busy;
  logic              tx_load;
  logic [DATA_W-1:0] tx_byte;
  logic [DATA_W-1:0] fuse_rdata;
  logic [DATA_W-1:0] sig_rdata;
  logic              do_fuse_wr, do_fuse_rd, do_sig_wr, do_sig_rd;
  logic              do_preload, do_secure, do_erase, do_clr;
  logic              deny_evt;
  logic              unused_cmd_bits;

  assign tx_busy = out_valid;

  fac_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync     (frame_sync),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .hold     (tx_busy),
    .in_ready (in_ready),
    .frame_vld(cmd_vld),
    .frame    (cmd)
  );

  always_comb begin
    do_fuse_wr = 1'b0; do_fuse_rd = 1'b0; do_sig_wr  = 1'b0; do_sig_rd = 1'b0;
    do_preload = 1'b0; do_secure  = 1'b0; do_erase   = 1'b0; do_clr    = 1'b0;
    if (cmd_vld) begin
      case (cmd.op)
        OP_FUSE_WR:  do_fuse_wr = 1'b1;
        OP_FUSE_RD:  do_fuse_rd = 1'b1;
        OP_SIG_WR:   do_sig_wr  = 1'b1;
        OP_SIG_RD:   do_sig_rd  = 1'b1;
        OP_PRELOAD:  do_preload = 1'b1;
        OP_SECURE:   do_secure  = 1'b1;
        OP_ERASE:    do_erase   = 1'b1;
        OP_CLR_DENY: do_clr     = 1'b1;
        default: ;
      endcase
    end
  end

  assign unused_cmd_bits = ^cmd;

  fac_store #(
    .WORDS    (FUSE_WORDS),
    .SIG_BYTES(SIG_BYTES)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .fuse_we   (do_fuse_wr),
    .sig_we    (do_sig_wr),
    .erase     (do_erase),
    .set_sec   (do_secure),
    .fuse_addr (cmd.addr[FA_W-1:0]),
    .sig_addr  (cmd.addr[SA_W-1:0]),
    .wdata     (cmd.data),
    .fuse_rdata(fuse_rdata),
    .sig_rdata (sig_rdata),
    .fuse_flat (fuse_map),
    .secure    (secure)
  );

  assign deny_evt = secure && (do_fuse_rd || do_preload);
  assign tx_load  = do_fuse_rd || do_sig_rd;
  assign tx_byte  = do_sig_rd ? sig_rdata : (secure ? '0 : fuse_rdata);

  fac_tx #(.W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_load),
    .load_byte(tx_byte),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_bit  (out_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      denied      <= 1'b0;
      preload_en  <= '0;
      preload_val <= '0;
    end else begin
      if (do_clr)        denied <= 1'b0;
      else if (deny_evt) denied <= 1'b1;
      preload_en <= '0;
      if (do_preload && !secure) begin
        preload_en  <= cmd.addr[NUM_OUT-1:0];
        preload_val <= cmd.data[NUM_OUT-1:0];
      end
    end
  end

  AST_BUSY_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2
  AST_PRELOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    secure |=> preload_en == '0); // R9
  AST_PRELOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en != '0 |=> preload_en == '0); // R6
  AST_DENY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    denied && !do_clr |=> denied); // R8
  AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    do_fuse_rd && secure |=> out_valid && !out_bit && denied); // R8
endmodule

// File: tb/fuse_access_ctrl_test.sv
module fuse_access_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_sync = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_bit = 1'b0;
  logic         in_ready;
  logic         out_valid;
  logic         out_bit;
  logic         out_ready = 1'b1;
  logic [255:0] fuse_map;
  logic [7:0]   preload_en;
  logic [7:0]   preload_val;
  logic         secure;
  logic         denied;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fuse_access_ctrl uut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_bit(out_bit), .out_ready(out_ready),
    .fuse_map(fuse_map), .preload_en(preload_en), .preload_val(preload_val),
    .secure(secure), .denied(denied)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [3:0] op, input logic [7:0] addr, input logic [7:0] data);
    logic [19:0] f;
    f = {op, addr, data};
    for (int i = 19; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    int g;
    b = '0;
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      g = 0;
      while (!out_valid && g < 50) begin @(negedge clk); g++; end
      b = {b[6:0], out_bit};
      @(negedge clk);
    end
  endtask

  task automatic read_fuse(input logic [7:0] addr, output logic [7:0] b);
    send_frame(4'd2, addr, 8'h00);
    recv_byte(b);
  endtask

  task automatic read_sig(input logic [7:0] addr, output logic [7:0] b);
    send_frame(4'd4, addr, 8'h00);
    recv_byte(b);
  endtask

  task automatic t_reset;
    chk("R12 in_ready", 64'(in_ready), 1);
    chk("R12 out_valid", 64'(out_valid), 0);
    chk("R12 secure", 64'(secure), 0);
    chk("R12 denied", 64'(denied), 0);
    chk("R12 preload_en", 64'(preload_en), 0);
    chk("R12 fuse blank", 64'(&fuse_map), 1);
  endtask

  task automatic t_fuse_rw;
    logic [7:0] b;
    send_frame(4'd1, 8'd3, 8'hA5);
    send_frame(4'd1, 8'd31, 8'h3C);
    read_fuse(8'd3, b);
    chk("R4 read word 3", 64'(b), 64'hA5);
    read_fuse(8'd35, b);
    chk("R4 address alias", 64'(b), 64'hA5);
    chk("R4 fuse_map word 31", 64'(fuse_map[255:248]), 64'h3C);
    chk("R3 out_valid drops", 64'(out_valid), 0);
  endtask

  task automatic t_backpressure;
    logic [7:0] b;
    send_frame(4'd1, 8'd5, 8'h96);
    out_ready = 1'b0;
    send_frame(4'd2, 8'd5, 8'h00);
    @(negedge clk);
    chk("R3 valid under stall", 64'(out_valid), 1);
    chk("R2 in_ready low", 64'(in_ready), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 bit held", 64'({out_valid, out_bit}), 64'b11);
    end
    chk("R2 in_ready still low", 64'(in_ready), 0);
    recv_byte(b);
    chk("R3 MSB first", 64'(b), 64'h96);
    chk("R2 in_ready back", 64'(in_ready), 1);
  endtask

  task automatic t_sync;
    logic [7:0] b;
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
    send_frame(4'd1, 8'd9, 8'h5A);
    read_fuse(8'd9, b);
    chk("R1 sync realigns", 64'(b), 64'h5A);
  endtask

  task automatic t_sig;
    logic [7:0] b;
    for (int i = 0; i < 8; i++) send_frame(4'd3, 8'(i), 8'(8'h10 + i * 3));
    read_sig(8'd2, b);
    chk("R5 sig byte 2", 64'(b), 64'h16);
    read_sig(8'd15, b);
    chk("R5 sig byte 7 alias", 64'(b), 64'h25);
  endtask

  task automatic t_preload;
    send_frame(4'd5, 8'h0F, 8'hA5);
    @(negedge clk);
    chk("R6 mask", 64'(preload_en), 64'h0F);
    chk("R6 values", 64'(preload_val), 64'hA5);
    @(negedge clk);
    chk("R6 one-cycle pulse", 64'(preload_en), 0);
  endtask

  task automatic t_unused;
    logic [7:0] b;
    send_frame(4'd9, 8'd3, 8'h00);
    @(negedge clk);
    chk("R11 op9 no response", 64'(out_valid), 0);
    send_frame(4'd0, 8'd3, 8'h00);
    @(negedge clk);
    chk("R11 op0 no flags", 64'({secure, denied, preload_en}), 0);
    send_frame(4'd15, 8'hFF, 8'hFF);
    @(negedge clk);
    chk("R11 op15 no flags", 64'({secure, denied, preload_en, out_valid}), 0);
    read_fuse(8'd3, b);
    chk("R11 fuse untouched", 64'(b), 64'hA5);
  endtask

  task automatic t_secure;
    logic [7:0] b;
    send_frame(4'd6, 8'd0, 8'd0);
    @(negedge clk);
    chk("R7 secure set", 64'(secure), 1);
    read_fuse(8'd3, b);
    chk("R8 locked read zero", 64'(b), 0);
    chk("R8 denied set", 64'(denied), 1);
    read_sig(8'd2, b);
    chk("R5 sig read when secure", 64'(b), 64'h16);
    send_frame(4'd3, 8'd2, 8'hC3);
    read_sig(8'd2, b);
    chk("R5 sig write when secure", 64'(b), 64'hC3);
    send_frame(4'd8, 8'd0, 8'd0);
    @(negedge clk);
    chk("R11 deny cleared", 64'(denied), 0);
    send_frame(4'd5, 8'hFF, 8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 no preload", 64'(preload_en), 0);
    end
    chk("R9 denied set", 64'(denied), 1);
    chk("R7 still secure", 64'(secure), 1);
  endtask

  task automatic t_erase;
    logic [7:0] b;
    send_frame(4'd7, 8'd0, 8'd0);
    @(negedge clk);
    chk("R10 secure cleared", 64'(secure), 0);
    chk("R10 fuses blank", 64'(&fuse_map), 1);
    read_fuse(8'd3, b);
    chk("R10 read blank", 64'(b), 64'hFF);
    read_sig(8'd2, b);
    chk("R10 sig kept", 64'(b), 64'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fuse_rw();
    t_backpressure();
    t_sync();
    t_sig();
    t_preload();
    t_unused();
    t_secure();
    t_erase();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule